// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer

This block is the digital sequencer for an integrating analog-to-digital converter that takes bipolar inputs. The integrator, amplifiers, comparators and analog switches sit outside it. The block steers them through a 2-bit select code and an input-inversion line. It reads back two comparators: one fires when the integrator output reaches the reference level, and the other fires when the integrator output crosses zero.

A processor pulses `start` while the block is idle. The sequencer then takes these steps:

- It integrates the input until the level comparator fires.
- It switches to the reference of the opposite sign and counts clocks until the zero-crossing comparator fires.
- It holds the integrator in zeroing for a fixed number of clocks.
- It pulses `done` and publishes the count, a polarity bit and an overrange flag.

These results stay fixed until the next conversion finishes. While the block is idle it keeps the integrator zeroed, so every integrate phase starts from zero. Each completed conversion reverses the orientation of both the input and the reference.

Top module: `dsadc_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it releases, `mux_sel` is 00 (zero), and `done`, `result`, `result_neg`, `overrange` and `in_invert` are all 0.
- R2: While idle, `mux_sel` stays 00. When `start` is sampled high in idle, `mux_sel` becomes 01 (input) on the next cycle.
- R3: `mux_sel` holds 01 until `ref_hit` is sampled high. On the next cycle it becomes the opposite reference: 11 (negative) when `in_invert` is 0, or 10 (positive) when `in_invert` is 1.
- R4: The published `result` equals the number of clock cycles spent in de-integration before the cycle in which `zero_cross` is sampled high.
- R5: If the count reaches full scale (all ones) without a zero crossing, `result` is all ones and `overrange` is 1. A zero crossing sampled in that same cycle wins, and `overrange` is then 0.
- R6: After de-integration, `mux_sel` is 00 for exactly ZERO_CYCLES cycles. `done` is then high for exactly one cycle, and the new results appear in that same cycle.
- R7: `result`, `result_neg` and `overrange` change only in a cycle where `done` is high.
- R8: `result_neg` reports the `in_invert` value used for the conversion. `in_invert` toggles after every completed conversion, including an overrange one.
- R9: `start` is ignored outside idle, `ref_hit` is ignored outside integrate, and `zero_cross` is ignored outside de-integrate.
- R10: `in_invert` does not change while `mux_sel` is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Conversion request from the processor |
| ref_hit | input | 1 | Comparator: integrator output has reached the reference level |
| zero_cross | input | 1 | Comparator: integrator output has returned to zero |
| mux_sel | output | 2 | Select code: 00 zero, 01 input, 10 positive reference, 11 negative reference |
| in_invert | output | 1 | Inverts the input orientation for the current conversion |
| done | output | 1 | One-cycle pulse when a result is published |
| result | output | CNT_W | De-integration count (magnitude) |
| result_neg | output | 1 | Orientation used for the published result |
| overrange | output | 1 | Count saturated without a zero crossing |

## Verification
A wrong phase shows up on `mux_sel` within one cycle of the comparator or start event that should have moved it. The bench samples the select code on every cycle of every phase. A counter that is off by one, or starts from the wrong value, shows up in the published `result` when `done` pulses, and the bench sweeps every de-integration length of a 6-bit counter to catch it. A lost or doubled polarity toggle shows up on `in_invert` at the very next conversion and on `result_neg` at its `done`.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    MUX_ZERO   = 2'b00,
    MUX_INPUT  = 2'b01,
    MUX_POSREF = 2'b10,
    MUX_NEGREF = 2'b11
  } mux_code_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2,
    PH_ZERO  = 2'd3
  } phase_t;
endpackage

// File: rtl/dsadc_rst_sync.sv
module dsadc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dsadc_deint_cnt.sv
module dsadc_deint_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  localparam logic [CNT_W-1:0] FULL_SCALE = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Cleared whenever de-integration is not running; advances only when told to.
  always_comb begin
    cnt_d = cnt_q;
    if (!run)     cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == FULL_SCALE);
endmodule

// File: rtl/dsadc_zero_timer.sv
module dsadc_zero_timer #(
  parameter int ZERO_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = (ZERO_CYCLES > 1) ? $clog2(ZERO_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(ZERO_CYCLES - 1);

  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    tmr_d = tmr_q;
    if (!run)            tmr_d = '0;
    else if (!expired)   tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign expired = run && (tmr_q == LAST);
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ref_hit,
  input  logic             zero_cross,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_full,
  input  logic             zero_expired,
  output logic             cnt_run,
  output logic             cnt_inc,
  output logic             zero_run,
  output mux_code_t        mux_code,
  output logic             in_invert,
  output logic             done,
  output logic [CNT_W-1:0] result,
  output logic             result_neg,
  output logic             overrange
);
  phase_t           ph_q, ph_d;
  logic             pol_q, pol_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             cap_ovr_q, cap_ovr_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             neg_q, neg_d;
  logic             ovr_q, ovr_d;
  logic             done_q, done_d;

  // Next-state and datapath enables
  always_comb begin
    ph_d      = ph_q;
    pol_d     = pol_q;
    cap_d     = cap_q;
    cap_ovr_d = cap_ovr_q;
    res_d     = res_q;
    neg_d     = neg_q;
    ovr_d     = ovr_q;
    done_d    = 1'b0;
    cnt_run   = 1'b0;
    cnt_inc   = 1'b0;
    zero_run  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) ph_d = PH_INTEG;
      end
      PH_INTEG: begin
        if (ref_hit) ph_d = PH_DEINT;
      end
      PH_DEINT: begin
        cnt_run = 1'b1;
        if (zero_cross) begin
          cap_d     = cnt;
          cap_ovr_d = 1'b0;
          ph_d      = PH_ZERO;
        end else if (cnt_full) begin
          cap_d     = cnt;
          cap_ovr_d = 1'b1;
          ph_d      = PH_ZERO;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      PH_ZERO: begin
        zero_run = 1'b1;
        if (zero_expired) begin
          res_d  = cap_q;
          ovr_d  = cap_ovr_q;
          neg_d  = pol_q;
          pol_d  = ~pol_q;
          done_d = 1'b1;
          ph_d   = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      pol_q     <= 1'b0;
      cap_q     <= '0;
      cap_ovr_q <= 1'b0;
      res_q     <= '0;
      neg_q     <= 1'b0;
      ovr_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      pol_q     <= pol_d;
      cap_q     <= cap_d;
      cap_ovr_q <= cap_ovr_d;
      res_q     <= res_d;
      neg_q     <= neg_d;
      ovr_q     <= ovr_d;
      done_q    <= done_d;
    end
  end

  // Select code decoded from the phase register
  always_comb begin
    unique case (ph_q)
      PH_INTEG: mux_code = MUX_INPUT;
      PH_DEINT: mux_code = pol_q ? MUX_POSREF : MUX_NEGREF;
      default:  mux_code = MUX_ZERO;
    endcase
  end

  assign in_invert  = pol_q;
  assign done       = done_q;
  assign result     = res_q;
  assign result_neg = neg_q;
  assign overrange  = ovr_q;
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ZERO_CYCLES = 256,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ref_hit,
  input  logic             zero_cross,
  output logic [1:0]       mux_sel,
  output logic             in_invert,
  output logic             done,
  output logic [CNT_W-1:0] result,
  output logic             result_neg,
  output logic             overrange
);
  logic             srst_n;
  logic [CNT_W-1:0] cnt;
  logic             cnt_full, cnt_run, cnt_inc;
  logic             zero_run, zero_expired;
  mux_code_t        mux_code;

  dsadc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  dsadc_deint_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .run(cnt_run), .inc(cnt_inc),
    .cnt(cnt), .full(cnt_full)
  );

  dsadc_zero_timer #(.ZERO_CYCLES(ZERO_CYCLES)) u_zero (
    .clk(clk), .rst_n(srst_n), .run(zero_run), .expired(zero_expired)
  );

  dsadc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(srst_n), .start(start), .ref_hit(ref_hit),
    .zero_cross(zero_cross), .cnt(cnt), .cnt_full(cnt_full),
    .zero_expired(zero_expired), .cnt_run(cnt_run), .cnt_inc(cnt_inc),
    .zero_run(zero_run), .mux_code(mux_code), .in_invert(in_invert),
    .done(done), .result(result), .result_neg(result_neg),
    .overrange(overrange)
  );

  assign mux_sel = mux_code;
endmodule

// File: rtl/dsadc_ctrl_chk.sv
module dsadc_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mux_sel,
  input logic             in_invert,
  input logic             done,
  input logic [CNT_W-1:0] result,
  input logic             result_neg,
  input logic             overrange
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mux_sel) == 2'b00));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(result_neg) && $stable(overrange)));

  // R5
  overrange_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrange |-> (result == {CNT_W{1'b1}}));

  // R3
  ref_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel[1] && ($past(mux_sel) != mux_sel)) |-> ($past(mux_sel) == 2'b01));

  // R3
  ref_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_sel[1] |-> (mux_sel[0] == !in_invert));

  // R10
  invert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mux_sel != 2'b00) && ($past(mux_sel) != 2'b00)) |-> $stable(in_invert));

  // R8
  invert_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (in_invert != result_neg));
endmodule

bind dsadc_ctrl dsadc_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .in_invert(in_invert),
  .done(done), .result(result), .result_neg(result_neg),
  .overrange(overrange)
);

// File: tb/dsadc_ctrl_test.sv
`timescale 1ns/1ps
module dsadc_ctrl_test;
  localparam int W    = 6;
  localparam int Z    = 4;
  localparam int FULL = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ref_hit = 1'b0, zero_cross = 1'b0;
  logic [1:0]   mux_sel;
  logic         in_invert, done, result_neg, overrange;
  logic [W-1:0] result;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit exp_pol = 1'b0;
  int prev_res = 0;
  bit prev_neg = 1'b0, prev_ovr = 1'b0;

  always #4 clk = ~clk;

  dsadc_ctrl #(.CNT_W(W), .ZERO_CYCLES(Z)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hit(ref_hit),
    .zero_cross(zero_cross), .mux_sel(mux_sel), .in_invert(in_invert),
    .done(done), .result(result), .result_neg(result_neg),
    .overrange(overrange)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One conversion. t_int: integrate cycles; m: de-integrate cycles before the
  // zero crossing; hit: 0 means no crossing (overrange); noise: ignored pulses.
  task automatic conv(input int t_int, input int m, input bit hit, input bit noise);
    int exp_cnt;
    bit exp_ovr;
    int ref_code;
    exp_cnt  = hit ? m : FULL;
    exp_ovr  = !hit;
    ref_code = exp_pol ? 2 : 3;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(mux_sel == 2'b01, "R2 input select after start", mux_sel, 1);
    chk(in_invert == exp_pol, "R8 orientation", in_invert, exp_pol);
    for (int i = 0; i < t_int; i++) begin
      if (noise) zero_cross = 1'b1;   // R9: ignored in integrate
      @(negedge clk);
      chk(mux_sel == 2'b01, "R3 integrate holds", mux_sel, 1);
    end
    zero_cross = 1'b0;
    ref_hit = 1'b1;
    @(negedge clk) ref_hit = 1'b0;
    chk(mux_sel == 2'(ref_code), "R3 opposite reference", mux_sel, ref_code);
    chk(result == W'(prev_res) && result_neg == prev_neg && overrange == prev_ovr,
        "R7 results held", result, prev_res);
    if (hit) begin
      for (int j = 0; j < m; j++) begin
        if (noise && j == 0) begin start = 1'b1; ref_hit = 1'b1; end  // R9
        @(negedge clk);
        start = 1'b0; ref_hit = 1'b0;
      end
      zero_cross = 1'b1;
      @(negedge clk) zero_cross = 1'b0;
    end else begin
      repeat (FULL + 1) @(negedge clk);
    end
    chk(mux_sel == 2'b00 && !done, "R6 zeroing entered", mux_sel, 0);
    for (int k = 0; k < Z - 1; k++) begin
      @(negedge clk);
      chk(mux_sel == 2'b00 && !done, "R6 zeroing held", {done, mux_sel}, 0);
    end
    @(negedge clk);
    chk(done == 1'b1, "R6 done pulse", done, 1);
    chk(result == W'(exp_cnt), "R4 count", result, exp_cnt);
    chk(overrange == exp_ovr, "R5 overrange flag", overrange, exp_ovr);
    chk(result_neg == exp_pol, "R8 result polarity", result_neg, exp_pol);
    @(negedge clk);
    chk(!done && mux_sel == 2'b00, "R6 single done / R2 idle", {done, mux_sel}, 0);
    chk(in_invert == !exp_pol, "R8 toggled", in_invert, !exp_pol);
    exp_pol  = !exp_pol;
    prev_res = exp_cnt;
    prev_neg = !exp_pol;
    prev_ovr = exp_ovr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mux_sel == 2'b00 && !done && result == '0 && !result_neg && !overrange && !in_invert,
        "R1 reset state", {done, mux_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mux_sel == 2'b00 && !done && result == '0 && !in_invert, "R1 after release", mux_sel, 0);
    repeat (3) @(negedge clk);
    // R9: comparators pulsing in idle have no effect
    ref_hit = 1'b1; zero_cross = 1'b1;
    @(negedge clk) begin ref_hit = 1'b0; zero_cross = 1'b0; end
    repeat (2) @(negedge clk);
    chk(mux_sel == 2'b00 && !done && result == '0, "R9 idle ignores comparators", mux_sel, 0);
    // R4 sweep of every de-integration length
    for (int m = 0; m <= FULL; m++) conv(1 + (m % 4), m, 1'b1, (m % 3) == 0);
    // R5 overrange in both orientations, then crossing on the full-scale cycle
    conv(2, 0, 1'b0, 1'b0);
    conv(3, 0, 1'b0, 1'b0);
    conv(1, FULL, 1'b1, 1'b0);
    summary();
  end
endmodule